// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block keeps the in-flight instructions of an out-of-order core in program order. Each instruction takes the next slot after the current tail when it is allocated. It leaves from the head once it has been marked ready to commit. A slot holds the instruction's sequence number, its PC and next PC, a ready flag and a squashed flag. Slots are numbered 0 to DEPTH-1. After reset they are handed out in allocation order and wrap modulo DEPTH, so the execution side can mark a slot ready by its index.

A squash request names a sequence number that marks the squash point. The buffer does not delete the younger entries at once. It walks backward from the tail, visiting at most SQ_W slots per cycle. Each slot it visits is flagged both squashed and ready, so these entries later drain through ordinary head retirement. The walk stops at the slot holding the squash sequence number, and that slot is left unchanged. If no slot matches, the walk stops once it has marked the head slot. While the walk runs, new allocations are dropped, but retirement continues. DEPTH must be a power of two and SQ_W must be smaller than DEPTH.

Top module: `rob_squash`

## Requirements
- R1: When `alloc_valid` is high, the buffer is not full and no squash is running or starting, the entry is written to the slot after the tail. The next cycle, `free_cnt` is one lower and `tail_seq`/`tail_pc` show the new entry. Slot indices wrap from DEPTH-1 to 0. An allocation while full is dropped and raises `proto_err` for exactly the next cycle.
- R2: `retire_req` while `head_ready` is high removes the head entry, and the next cycle shows the following entry. `retire_req` while `head_ready` is low has no effect.
- R3: `head_ready` is low whenever the buffer is empty. Otherwise it equals the ready flag of the head slot. `free_cnt` equals DEPTH minus the occupancy. After reset, `free_cnt` is DEPTH, `head_ready` is 0, `squash_done` is 1 and `proto_err` is 0.
- R4: `mark_valid` together with `mark_idx` sets the ready flag of that slot, and the effect is visible the next cycle.
- R5: A `squash_valid` request on a non-empty buffer, with no walk running, records `squash_seq`. `squash_done` is low from the next cycle on. The walk starts in the following cycle at the tail slot.
- R6: Each walk cycle marks up to SQ_W slots as squashed and ready, going from the tail toward the head. The walk checks up to SQ_W+1 slots for a match. A slot whose sequence number equals the recorded squash number ends the walk and is not marked. `squash_done` is high in the cycle after the walk cycle that found the match.
- R7: If no slot matches, the walk marks the head slot and then ends, and `squash_done` rises the next cycle.
- R8: `squash_valid` on an empty buffer starts no walk, leaves `squash_done` high and raises `proto_err` for the next cycle.
- R9: During a walk, allocations are dropped without an error, while a retirement of a ready head entry still takes place.
- R10: `head_squashed` shows the squashed flag of the head slot while the buffer is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate an entry at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new entry |
| alloc_pc | input | PC_W | PC of the new entry |
| alloc_npc | input | PC_W | Next PC of the new entry |
| mark_valid | input | 1 | Mark a slot ready to commit |
| mark_idx | input | log2(DEPTH) | Slot to mark |
| retire_req | input | 1 | Retire the head entry if it is ready |
| squash_valid | input | 1 | Start a squash walk |
| squash_seq | input | SEQ_W | Sequence number of the squash point |
| free_cnt | output | log2(DEPTH)+1 | Number of free slots |
| head_ready | output | 1 | Head entry may retire |
| head_squashed | output | 1 | Head entry was squashed |
| head_seq | output | SEQ_W | Sequence number of the head entry |
| head_pc | output | PC_W | PC of the head entry |
| head_npc | output | PC_W | Next PC of the head entry |
| tail_seq | output | SEQ_W | Sequence number of the tail entry |
| tail_pc | output | PC_W | PC of the tail entry |
| squash_done | output | 1 | No squash walk is running |
| proto_err | output | 1 | Illegal allocation or squash in the previous cycle |

## Verification
Allocation, marking, retirement and the error flag each take effect one clock edge after the request, so every such check is made at the falling edge that follows that single rising edge. A squash drops `squash_done` one edge after the request. It then needs max(1, ceil(N/SQ_W)) further edges, where N is the number of slots to mark. The bench therefore checks that `squash_done` is still low one edge before that count and high exactly at it. Checks on dropped allocations and concurrent retirement are made at edges inside the walk window.

// File: rtl/rob_squash.sv
module rob_squash #(
  parameter int DEPTH = 8,
  parameter int SQ_W  = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  input  logic [SEQ_W-1:0]           alloc_seq,
  input  logic [PC_W-1:0]            alloc_pc,
  input  logic [PC_W-1:0]            alloc_npc,
  input  logic                       mark_valid,
  input  logic [$clog2(DEPTH)-1:0]   mark_idx,
  input  logic                       retire_req,
  input  logic                       squash_valid,
  input  logic [SEQ_W-1:0]           squash_seq,
  output logic [$clog2(DEPTH):0]     free_cnt,
  output logic                       head_ready,
  output logic                       head_squashed,
  output logic [SEQ_W-1:0]           head_seq,
  output logic [PC_W-1:0]            head_pc,
  output logic [PC_W-1:0]            head_npc,
  output logic [SEQ_W-1:0]           tail_seq,
  output logic [PC_W-1:0]            tail_pc,
  output logic                       squash_done,
  output logic                       proto_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [PC_W-1:0]  npc_q [DEPTH];
  logic [DEPTH-1:0] rdy_q, sqd_q;

  logic [PTR_W-1:0] head, tail, slot, wp, wp_n, pos;
  logic [CNT_W-1:0] cnt;
  logic             walking, err_q, full, empty;
  logic             alloc_ok, retire_ok, sq_start, sq_fin, stop;
  logic [SEQ_W-1:0] sq_seq;
  logic [DEPTH-1:0] sq_mark;

  assign full      = cnt == CNT_W'(DEPTH);
  assign empty     = cnt == '0;
  assign tail      = head + cnt[PTR_W-1:0] - PTR_W'(1);
  assign slot      = head + cnt[PTR_W-1:0];
  assign sq_start  = squash_valid && !walking && !empty;
  assign alloc_ok  = alloc_valid && !full && !walking && !sq_start;
  assign retire_ok = retire_req && head_ready;

  assign free_cnt      = CNT_W'(DEPTH) - cnt;
  assign head_ready    = !empty && rdy_q[head];
  assign head_squashed = !empty && sqd_q[head];
  assign head_seq      = seq_q[head];
  assign head_pc       = pc_q[head];
  assign head_npc      = npc_q[head];
  assign tail_seq      = seq_q[tail];
  assign tail_pc       = pc_q[tail];
  assign squash_done   = !walking;
  assign proto_err     = err_q;

  always_comb begin
    sq_mark = '0;
    sq_fin  = 1'b0;
    stop    = 1'b0;
    pos     = wp;
    for (int k = 0; k <= SQ_W; k++) begin
      pos = wp - PTR_W'(k);
      if (!stop) begin
        if (seq_q[pos] == sq_seq) begin
          sq_fin = 1'b1;
          stop   = 1'b1;
        end else if (k < SQ_W) begin
          sq_mark[pos] = 1'b1;
          if (pos == head) begin
            sq_fin = 1'b1;
            stop   = 1'b1;
          end
        end
      end
    end
    wp_n = wp - PTR_W'(SQ_W);
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      seq_q[slot] <= alloc_seq;
      pc_q[slot]  <= alloc_pc;
      npc_q[slot] <= alloc_npc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      cnt     <= '0;
      walking <= 1'b0;
      wp      <= '0;
      sq_seq  <= '0;
      err_q   <= 1'b0;
      rdy_q   <= '0;
      sqd_q   <= '0;
    end else begin
      err_q <= (alloc_valid && full) || (squash_valid && empty);
      cnt   <= cnt + CNT_W'(alloc_ok) - CNT_W'(retire_ok);
      if (retire_ok) head <= head + PTR_W'(1);
      for (int i = 0; i < DEPTH; i++) begin
        if (walking && sq_mark[i]) begin
          rdy_q[i] <= 1'b1;
          sqd_q[i] <= 1'b1;
        end else if (mark_valid && mark_idx == PTR_W'(i)) begin
          rdy_q[i] <= 1'b1;
        end
      end
      if (alloc_ok) begin
        rdy_q[slot] <= 1'b0;
        sqd_q[slot] <= 1'b0;
      end
      if (sq_start) begin
        walking <= 1'b1;
        wp      <= tail;
        sq_seq  <= squash_seq;
      end else if (walking) begin
        if (sq_fin) walking <= 1'b0;
        else        wp      <= wp_n;
      end
    end
  end

  // R3
  empty_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == CNT_W'(DEPTH)) |-> !head_ready);

  // R1
  full_alloc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && free_cnt == '0) |=> proto_err);

  // R2
  retire_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_req && head_ready && !alloc_valid) |=> free_cnt == $past(free_cnt) + CNT_W'(1));

  // R5
  squash_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && squash_done && free_cnt != CNT_W'(DEPTH)) |=> !squash_done);

  // R9
  walk_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!squash_done && !retire_req) |=> free_cnt == $past(free_cnt));

  // R8
  empty_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && squash_done && free_cnt == CNT_W'(DEPTH)) |=> (squash_done && proto_err));
endmodule

// File: tb/rob_squash_tb.sv
module rob_squash_tb;
  localparam int DEPTH = 8;
  localparam int SQ_W  = 2;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [SEQ_W-1:0] alloc_seq = '0;
  logic [PC_W-1:0] alloc_pc = '0, alloc_npc = '0;
  logic mark_valid = 1'b0;
  logic [2:0] mark_idx = '0;
  logic retire_req = 1'b0, squash_valid = 1'b0;
  logic [SEQ_W-1:0] squash_seq = '0;
  logic [3:0] free_cnt;
  logic head_ready, head_squashed, squash_done, proto_err;
  logic [SEQ_W-1:0] head_seq, tail_seq;
  logic [PC_W-1:0] head_pc, head_npc, tail_pc;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rob_squash #(.DEPTH(DEPTH), .SQ_W(SQ_W), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_pc(alloc_pc), .alloc_npc(alloc_npc), .mark_valid(mark_valid),
    .mark_idx(mark_idx), .retire_req(retire_req), .squash_valid(squash_valid),
    .squash_seq(squash_seq), .free_cnt(free_cnt), .head_ready(head_ready),
    .head_squashed(head_squashed), .head_seq(head_seq), .head_pc(head_pc),
    .head_npc(head_npc), .tail_seq(tail_seq), .tail_pc(tail_pc),
    .squash_done(squash_done), .proto_err(proto_err));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0; mark_valid = 1'b0; retire_req = 1'b0; squash_valid = 1'b0;
  endtask

  function automatic int pc_of(input int s);
    return 32'h1000 + s * 4;
  endfunction

  task automatic alloc(input int s);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(s);
    alloc_pc = PC_W'(pc_of(s)); alloc_npc = PC_W'(pc_of(s) + 4);
    tick();
  endtask

  task automatic mark(input int idx);
    mark_valid = 1'b1; mark_idx = 3'(idx); tick();
  endtask

  task automatic retire();
    retire_req = 1'b1; tick();
  endtask

  task automatic squash(input int s);
    squash_valid = 1'b1; squash_seq = SEQ_W'(s); tick();
  endtask

  task automatic t_reset();
    check("R3 reset free", int'(free_cnt), DEPTH);
    check("R3 reset head_ready", int'(head_ready), 0);
    check("R3 reset done", int'(squash_done), 1);
    check("R3 reset err", int'(proto_err), 0);
  endtask

  task automatic t_alloc_retire();
    for (int s = 10; s < 15; s++) alloc(s);
    check("R1 free after 5", int'(free_cnt), 3);
    check("R1 tail seq", int'(tail_seq), 14);
    check("R1 tail pc", int'(tail_pc), pc_of(14));
    check("R1 head npc", int'(head_npc), pc_of(10) + 4);
    check("R3 not ready head", int'(head_ready), 0);
    retire();
    check("R2 unready retire ignored", int'(free_cnt), 3);
    check("R2 head kept", int'(head_seq), 10);
    mark(0);
    check("R4 mark sets ready", int'(head_ready), 1);
    retire();
    check("R2 retire frees", int'(free_cnt), 4);
    check("R2 next head", int'(head_seq), 11);
    check("R2 next head pc", int'(head_pc), pc_of(11));
  endtask

  task automatic t_squash_match();
    squash(11);
    check("R5 done drops", int'(squash_done), 0);
    alloc(99);
    check("R9 alloc dropped", int'(free_cnt), 4);
    check("R6 still walking", int'(squash_done), 0);
    tick();
    check("R6 walk done", int'(squash_done), 1);
    check("R9 tail unchanged", int'(tail_seq), 14);
    check("R6 match not marked", int'(head_ready), 0);
    check("R10 match not squashed", int'(head_squashed), 0);
    mark(1);
    retire();
    check("R6 younger ready", int'(head_ready), 1);
    check("R10 younger squashed", int'(head_squashed), 1);
    check("R6 head seq", int'(head_seq), 12);
    for (int i = 0; i < 3; i++) retire();
    check("R3 empty free", int'(free_cnt), DEPTH);
    check("R3 empty not ready", int'(head_ready), 0);
  endtask

  task automatic t_squash_nomatch();
    for (int s = 20; s < 24; s++) alloc(s);
    check("R1 wrap tail seq", int'(tail_seq), 23);
    check("R1 wrap head seq", int'(head_seq), 20);
    squash(5);
    check("R5 done drops", int'(squash_done), 0);
    tick();
    check("R7 walk continues", int'(squash_done), 0);
    check("R7 head not yet marked", int'(head_ready), 0);
    tick();
    check("R7 walk ends at head", int'(squash_done), 1);
    check("R7 head marked ready", int'(head_ready), 1);
    check("R10 head squashed", int'(head_squashed), 1);
    for (int i = 0; i < 4; i++) retire();
    check("R7 drained", int'(free_cnt), DEPTH);
  endtask

  task automatic t_retire_during_walk();
    for (int s = 30; s < 34; s++) alloc(s);
    mark(1);
    squash(31);
    retire_req = 1'b1;
    tick();
    check("R9 retire in walk", int'(free_cnt), 5);
    check("R6 single cycle walk", int'(squash_done), 1);
    check("R9 head after retire", int'(head_seq), 31);
    mark(2);
    for (int i = 0; i < 3; i++) retire();
    check("R2 drained", int'(free_cnt), DEPTH);
  endtask

  task automatic t_full();
    for (int s = 40; s < 48; s++) alloc(s);
    check("R1 full", int'(free_cnt), 0);
    alloc(48);
    check("R1 full err", int'(proto_err), 1);
    check("R1 full no write", int'(tail_seq), 47);
    check("R1 full count", int'(free_cnt), 0);
    tick();
    check("R1 err one cycle", int'(proto_err), 0);
    for (int i = 0; i < DEPTH; i++) mark(i);
    for (int i = 0; i < DEPTH; i++) retire();
    check("R2 empty after drain", int'(free_cnt), DEPTH);
  endtask

  task automatic t_squash_empty();
    squash(3);
    check("R8 err", int'(proto_err), 1);
    check("R8 no walk", int'(squash_done), 1);
    tick();
    check("R8 still idle", int'(squash_done), 1);
    check("R8 err clears", int'(proto_err), 0);
  endtask

  task automatic t_squash_at_tail();
    alloc(50);
    alloc(51);
    squash(51);
    check("R5 done drops", int'(squash_done), 0);
    tick();
    check("R6 tail match done", int'(squash_done), 1);
    check("R6 nothing marked", int'(head_ready), 0);
    check("R6 free kept", int'(free_cnt), DEPTH - 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_retire();
    t_squash_match();
    t_squash_nomatch();
    t_retire_during_walk();
    t_full();
    t_squash_empty();
    t_squash_at_tail();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule